// File: doc/BRIEF.md
# Configurable Macrocell Register Stage

This block is the back end of one programmable-logic macrocell. It takes an OR sum term and a handful of spare product terms. It forms a polarity-adjusted combinational value and keeps one bit of state. The bit can behave as a D, T, JK or SR flip-flop, or as a flow-through latch. The block then drives a pin value with its output enable, plus a separate buried feedback bit. Static configuration inputs choose every option. Software sets them once, and they are expected to stay constant during operation.

The block runs on one system clock. The macrocell's own clock sources are three global clock inputs and a product-term clock. These are sampled as levels, and a storage edge is taken when the selected source is seen rising. The reset and preset controls act on the visible stored value in the same cycle they are asserted, and the stored bit takes that value at the next system edge. A power-down mode freezes both the state and the outputs.

Top module: `mcell_reg_stage`

## Requirements
- R1: The combinational value equals orSum XOR a second operand. cfgXor selects that operand: 0 gives constant 0, 1 gives constant 1, and 2 or 3 give ptXor.
- R2: The storage data input is chosen by cfgDsel: 0 selects the combinational value, 1 selects ptData, and 2 or 3 select pinIn.
- R3: In D mode (cfgMode=0) a storage edge loads the data input. In T mode (cfgMode=1) a storage edge XORs the data input into the stored bit.
- R4: In JK mode (cfgMode=2), J is the data input and K is ptAux. On a storage edge, J=0,K=0 holds the bit, 1,0 sets it, 0,1 clears it, and 1,1 toggles it.
- R5: In SR mode (cfgMode=3), S is the data input and R is ptAux. On a storage edge, 1,0 sets the bit, 0,1 clears it, and 0,0 or 1,1 hold it.
- R6: In latch mode (cfgMode=4), whenever the selected clock is high the stored view shows the data input in that same cycle and the bit takes it. While the clock is low the bit holds. Clock edges and clock enable play no part in this mode. cfgMode values 5 to 7 behave as D mode.
- R7: cfgClk values 0 to 2 select gclk[0..2], and 3 selects ptClk. A storage edge occurs at the first system clock edge that samples the selected source high after a system edge that sampled it low.
- R8: With a global clock selected and cfgCeEn=1, storage edges that occur while ptCe is low are ignored. With ptClk selected, ptCe has no effect.
- R9: cfgRst selects the reset source: 0 off, 1 gclear, 2 ptRst, 3 gclear OR ptRst. The preset is ptSet gated by cfgSetEn. While either is active, the stored view is forced to 0 (reset) or 1 (preset) in the same cycle, and the bit takes that value at the next system edge. Reset wins when both are active.
- R10: pinOut shows the stored view when cfgOutReg=1 and the combinational value otherwise. feedback does the same under cfgFbReg, independently of pinOut.
- R11: cfgPin selects the pin direction: 0 input (pinOe=0), 1 output (pinOe=1), 2 or 3 bidirectional. In bidirectional use, cfgOe selects pinOe: 0 oePin[0], 1 its complement, 2 oePin[1], 3 its complement.
- R12: Power-down is active when cfgPdEn=1 and any pdPin bit is high. While it is active, pinOut, pinOe and feedback keep the values they had at the last system edge before it began. The stored bit does not change, and edges, latch transparency, reset and preset are all ignored. Clock transitions during power-down do not produce an edge on wake-up.
- R13: While rstN is low, the stored bit, the clock history and the held output values are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset |
| orSum | input | 1 | OR sum term |
| ptXor | input | 1 | Product term for the second XOR operand |
| ptData | input | 1 | Dedicated data product term |
| ptAux | input | 1 | K / R product term |
| ptClk | input | 1 | Product-term clock |
| ptCe | input | 1 | Product-term clock enable |
| ptRst | input | 1 | Product-term reset |
| ptSet | input | 1 | Product-term preset |
| pinIn | input | 1 | Value seen on the I/O pin |
| gclk | input | 3 | Global clock levels |
| gclear | input | 1 | Global clear |
| oePin | input | 2 | Dedicated output-enable pins |
| pdPin | input | 2 | Power-down pins |
| cfgXor | input | 2 | Second XOR operand select |
| cfgDsel | input | 2 | Storage data select |
| cfgMode | input | 3 | Storage mode |
| cfgClk | input | 2 | Clock source select |
| cfgCeEn | input | 1 | Clock enable use |
| cfgRst | input | 2 | Reset source select |
| cfgSetEn | input | 1 | Preset enable |
| cfgOutReg | input | 1 | Pin shows stored view |
| cfgFbReg | input | 1 | Feedback shows stored view |
| cfgPin | input | 2 | Pin direction |
| cfgOe | input | 2 | Bidirectional OE select |
| cfgPdEn | input | 1 | Power-down enable |
| pinOut | output | 1 | Pin output value |
| pinOe | output | 1 | Pin output enable |
| feedback | output | 1 | Buried feedback |

## Verification
The bench sweeps every mode against every clock source and reset source, and compares each cycle with its own cycle model. It targets several corner cases, each with a distinct failure:
- Reset and preset asserted together: a design with the priority inverted would show 1.
- JK and SR modes with both inputs high: swapping toggle and hold makes the bit flip where it should stay, or stay where it should flip.
- A clock enable that leaks into product-term clocking would drop edges.
- Clock transitions during power-down: a design that stops its clock history while frozen fires a spurious edge on wake-up.
- Outputs during power-down: outputs that track live inputs instead of the pre-power-down snapshot are caught on the first frozen cycle.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  localparam logic [2:0] MODE_D     = 3'd0;
  localparam logic [2:0] MODE_T     = 3'd1;
  localparam logic [2:0] MODE_JK    = 3'd2;
  localparam logic [2:0] MODE_SR    = 3'd3;
  localparam logic [2:0] MODE_LATCH = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;    // storage edge this cycle
    logic transp;  // latch open this cycle
    logic rst;     // effective reset
    logic set;     // effective preset
    logic frozen;  // power-down hold
  } strobe_t;

endpackage

// File: rtl/mcell_ctrl.sv
module mcell_ctrl
  import mcell_pkg::*;
#(
  parameter int NumGclk = 3,
  parameter int NumPd   = 2,
  localparam int ClkW   = $clog2(NumGclk + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumGclk-1:0] gclk,
  input  logic               ptClk,
  input  logic               ptCe,
  input  logic               gclear,
  input  logic               ptRst,
  input  logic               ptSet,
  input  logic [NumPd-1:0]   pdPin,
  input  logic [ClkW-1:0]    cfgClk,
  input  logic               cfgCeEn,
  input  logic [1:0]         cfgRst,
  input  logic               cfgSetEn,
  input  logic               cfgPdEn,
  input  logic               latchMode,
  output strobe_t            strb
);

  logic selLvl;
  logic prevLvl;
  logic isGlobal;
  logic ceOk;
  logic rstSrc;

  always_comb begin
    selLvl = ptClk;
    for (int i = 0; i < NumGclk; i++) begin
      if (cfgClk == ClkW'(i)) selLvl = gclk[i];
    end
  end

  assign isGlobal = (cfgClk < ClkW'(NumGclk));
  assign ceOk     = !isGlobal || !cfgCeEn || ptCe;

  always_comb begin
    case (cfgRst)
      2'd1:    rstSrc = gclear;
      2'd2:    rstSrc = ptRst;
      2'd3:    rstSrc = gclear | ptRst;
      default: rstSrc = 1'b0;
    endcase
  end

  // history keeps tracking while frozen so wake-up sees no stale edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= selLvl;
  end

  always_comb begin
    strb.frozen = cfgPdEn && (|pdPin);
    strb.rst    = rstSrc && !strb.frozen;
    strb.set    = cfgSetEn && ptSet && !strb.frozen;
    strb.transp = latchMode && selLvl && !strb.frozen;
    strb.tick   = selLvl && !prevLvl && ceOk && !latchMode && !strb.frozen;
  end

  p_ce_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isGlobal && cfgCeEn && !ptCe) |-> !strb.tick);

  p_no_edge_in_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    latchMode |-> !strb.tick);

endmodule

// File: rtl/mcell_dpath.sv
module mcell_dpath
  import mcell_pkg::*;
#(
  parameter int NumOe = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             orSum,
  input  logic             ptXor,
  input  logic             ptData,
  input  logic             ptAux,
  input  logic             pinIn,
  input  logic [NumOe-1:0] oePin,
  input  logic [1:0]       cfgXor,
  input  logic [1:0]       cfgDsel,
  input  logic [2:0]       cfgMode,
  input  logic             cfgOutReg,
  input  logic             cfgFbReg,
  input  logic [1:0]       cfgPin,
  input  logic [1:0]       cfgOe,
  input  strobe_t          strb,
  output logic             pinOut,
  output logic             pinOe,
  output logic             feedback
);

  logic xorOther, xorOut, dIn;
  logic stateQ, edgeNext, regView;
  logic liveOut, liveOe, liveFb;
  logic holdOut, holdOe, holdFb;

  always_comb begin
    case (cfgXor)
      2'd0:    xorOther = 1'b0;
      2'd1:    xorOther = 1'b1;
      default: xorOther = ptXor;
    endcase
    xorOut = orSum ^ xorOther;
    case (cfgDsel)
      2'd0:    dIn = xorOut;
      2'd1:    dIn = ptData;
      default: dIn = pinIn;
    endcase
  end

  always_comb begin
    case (cfgMode)
      MODE_T:  edgeNext = stateQ ^ dIn;
      MODE_JK: case ({dIn, ptAux})
                 2'b10:   edgeNext = 1'b1;
                 2'b01:   edgeNext = 1'b0;
                 2'b11:   edgeNext = !stateQ;
                 default: edgeNext = stateQ;
               endcase
      MODE_SR: case ({dIn, ptAux})
                 2'b10:   edgeNext = 1'b1;
                 2'b01:   edgeNext = 1'b0;
                 default: edgeNext = stateQ;
               endcase
      default: edgeNext = dIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            stateQ <= 1'b0;
    else if (strb.frozen) stateQ <= stateQ;
    else if (strb.rst)    stateQ <= 1'b0;
    else if (strb.set)    stateQ <= 1'b1;
    else if (strb.transp) stateQ <= dIn;
    else if (strb.tick)   stateQ <= edgeNext;
  end

  always_comb begin
    if (strb.rst)         regView = 1'b0;
    else if (strb.set)    regView = 1'b1;
    else if (strb.transp) regView = dIn;
    else                  regView = stateQ;
  end

  always_comb begin
    liveOut = cfgOutReg ? regView : xorOut;
    liveFb  = cfgFbReg  ? regView : xorOut;
    case (cfgPin)
      2'd0:    liveOe = 1'b0;
      2'd1:    liveOe = 1'b1;
      default: case (cfgOe)
                 2'd0:    liveOe = oePin[0];
                 2'd1:    liveOe = !oePin[0];
                 2'd2:    liveOe = oePin[1];
                 default: liveOe = !oePin[1];
               endcase
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdOut <= 1'b0;
      holdOe  <= 1'b0;
      holdFb  <= 1'b0;
    end else if (!strb.frozen) begin
      holdOut <= liveOut;
      holdOe  <= liveOe;
      holdFb  <= liveFb;
    end
  end

  assign pinOut   = strb.frozen ? holdOut : liveOut;
  assign pinOe    = strb.frozen ? holdOe  : liveOe;
  assign feedback = strb.frozen ? holdFb  : liveFb;

  p_reset_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.rst |=> (stateQ == 1'b0));

  p_preset_loads_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.set && !strb.rst) |=> (stateQ == 1'b1));

  p_quiet_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.tick || strb.transp || strb.rst || strb.set) |=> $stable(stateQ));

  p_frozen_state_r12: assert property (@(posedge clk) disable iff (!rstN)
    strb.frozen |=> $stable(stateQ));

  p_frozen_pins_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frozen && $past(strb.frozen)) |-> $stable({pinOut, pinOe, feedback}));

endmodule

// File: rtl/mcell_reg_stage.sv
module mcell_reg_stage
  import mcell_pkg::*;
#(
  parameter int NumGclk = 3,
  parameter int NumPd   = 2,
  parameter int NumOe   = 2,
  localparam int ClkW   = $clog2(NumGclk + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               orSum,
  input  logic               ptXor,
  input  logic               ptData,
  input  logic               ptAux,
  input  logic               ptClk,
  input  logic               ptCe,
  input  logic               ptRst,
  input  logic               ptSet,
  input  logic               pinIn,
  input  logic [NumGclk-1:0] gclk,
  input  logic               gclear,
  input  logic [NumOe-1:0]   oePin,
  input  logic [NumPd-1:0]   pdPin,
  input  logic [1:0]         cfgXor,
  input  logic [1:0]         cfgDsel,
  input  logic [2:0]         cfgMode,
  input  logic [ClkW-1:0]    cfgClk,
  input  logic               cfgCeEn,
  input  logic [1:0]         cfgRst,
  input  logic               cfgSetEn,
  input  logic               cfgOutReg,
  input  logic               cfgFbReg,
  input  logic [1:0]         cfgPin,
  input  logic [1:0]         cfgOe,
  input  logic               cfgPdEn,
  output logic               pinOut,
  output logic               pinOe,
  output logic               feedback
);

  strobe_t strb;

  mcell_ctrl #(.NumGclk(NumGclk), .NumPd(NumPd)) uCtrl (
    .clk(clk), .rstN(rstN), .gclk(gclk), .ptClk(ptClk), .ptCe(ptCe),
    .gclear(gclear), .ptRst(ptRst), .ptSet(ptSet), .pdPin(pdPin),
    .cfgClk(cfgClk), .cfgCeEn(cfgCeEn), .cfgRst(cfgRst),
    .cfgSetEn(cfgSetEn), .cfgPdEn(cfgPdEn),
    .latchMode(cfgMode == MODE_LATCH), .strb(strb)
  );

  mcell_dpath #(.NumOe(NumOe)) uDpath (
    .clk(clk), .rstN(rstN), .orSum(orSum), .ptXor(ptXor), .ptData(ptData),
    .ptAux(ptAux), .pinIn(pinIn), .oePin(oePin), .cfgXor(cfgXor),
    .cfgDsel(cfgDsel), .cfgMode(cfgMode), .cfgOutReg(cfgOutReg),
    .cfgFbReg(cfgFbReg), .cfgPin(cfgPin), .cfgOe(cfgOe), .strb(strb),
    .pinOut(pinOut), .pinOe(pinOe), .feedback(feedback)
  );

endmodule

// File: tb/tb_mcell_reg_stage.sv
`timescale 1ns/1ps
module tb_mcell_reg_stage;

  localparam time Period = 20ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic orSum = 0, ptXor = 0, ptData = 0, ptAux = 0, ptClk = 0, ptCe = 0;
  logic ptRst = 0, ptSet = 0, pinIn = 0, gclear = 0;
  logic [2:0] gclk = '0;
  logic [1:0] oePin = '0, pdPin = '0;
  logic [1:0] cfgXor = '0, cfgDsel = '0, cfgClk = '0, cfgRst = '0, cfgPin = '0, cfgOe = '0;
  logic [2:0] cfgMode = '0;
  logic cfgCeEn = 0, cfgSetEn = 0, cfgOutReg = 0, cfgFbReg = 0, cfgPdEn = 0;
  logic pinOut, pinOe, feedback;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  // reference model state
  logic mq = 0, mprev = 0, mhOut = 0, mhOe = 0, mhFb = 0;
  logic eOut, eOe, eFb, nq, curSel, curFrozen, curRS, lOut, lOe, lFb;

  always #(Period/2) clk = ~clk;

  mcell_reg_stage dut (
    .clk(clk), .rstN(rstN), .orSum(orSum), .ptXor(ptXor), .ptData(ptData),
    .ptAux(ptAux), .ptClk(ptClk), .ptCe(ptCe), .ptRst(ptRst), .ptSet(ptSet),
    .pinIn(pinIn), .gclk(gclk), .gclear(gclear), .oePin(oePin), .pdPin(pdPin),
    .cfgXor(cfgXor), .cfgDsel(cfgDsel), .cfgMode(cfgMode), .cfgClk(cfgClk),
    .cfgCeEn(cfgCeEn), .cfgRst(cfgRst), .cfgSetEn(cfgSetEn),
    .cfgOutReg(cfgOutReg), .cfgFbReg(cfgFbReg), .cfgPin(cfgPin), .cfgOe(cfgOe),
    .cfgPdEn(cfgPdEn), .pinOut(pinOut), .pinOe(pinOe), .feedback(feedback)
  );

  task automatic computeExpect();
    logic xo, d, rs, st, tk, tr, view, ceOk;
    xo = orSum ^ ((cfgXor == 0) ? 1'b0 : (cfgXor == 1) ? 1'b1 : ptXor);
    d = (cfgDsel == 0) ? xo : (cfgDsel == 1) ? ptData : pinIn;
    curSel = (cfgClk == 3) ? ptClk : gclk[cfgClk];
    curFrozen = cfgPdEn && (pdPin != 0);
    rs = !curFrozen && ((cfgRst == 1) ? gclear : (cfgRst == 2) ? ptRst :
                        (cfgRst == 3) ? (gclear | ptRst) : 1'b0);
    st = !curFrozen && cfgSetEn && ptSet;
    curRS = rs || st;
    ceOk = (cfgClk == 3) || !cfgCeEn || ptCe;
    tr = (cfgMode == 4) && curSel && !curFrozen;
    tk = curSel && !mprev && ceOk && (cfgMode != 4) && !curFrozen;
    view = rs ? 1'b0 : st ? 1'b1 : tr ? d : mq;
    nq = mq;
    if (curFrozen) nq = mq;
    else if (rs) nq = 0;
    else if (st) nq = 1;
    else if (tr) nq = d;
    else if (tk) begin
      case (cfgMode)
        3'd1: nq = mq ^ d;
        3'd2: nq = (d && ptAux) ? !mq : d ? 1'b1 : ptAux ? 1'b0 : mq;
        3'd3: nq = (d == ptAux) ? mq : d;
        default: nq = d;
      endcase
    end
    lOut = cfgOutReg ? view : xo;
    lFb = cfgFbReg ? view : xo;
    if (cfgPin == 0) lOe = 0;
    else if (cfgPin == 1) lOe = 1;
    else lOe = cfgOe[0] ^ oePin[cfgOe[1]];
    eOut = curFrozen ? mhOut : lOut;
    eOe = curFrozen ? mhOe : lOe;
    eFb = curFrozen ? mhFb : lFb;
  endtask

  task automatic modelAdvance();
    mq = nq;
    mprev = curSel;
    if (!curFrozen) begin mhOut = lOut; mhOe = lOe; mhFb = lFb; end
  endtask

  task automatic check(string tag, logic aO, logic aE, logic aF, logic xO, logic xE, logic xF);
    nChecks++;
    if ({aO, aE, aF} !== {xO, xE, xF}) begin
      nFails++;
      $display("FAIL %s t=%0t mode=%0d clk=%0d rst=%0d: got out/oe/fb=%b%b%b expected %b%b%b",
               tag, $time, cfgMode, cfgClk, cfgRst, aO, aE, aF, xO, xE, xF);
    end
  endtask

  // one cycle: inputs already applied after negedge
  task automatic stepCheck(string tag);
    #1;
    computeExpect();
    if (curFrozen) check("R12", pinOut, pinOe, feedback, eOut, eOe, eFb);
    else if (curRS) check("R9", pinOut, pinOe, feedback, eOut, eOe, eFb);
    else check(tag, pinOut, pinOe, feedback, eOut, eOe, eFb);
    modelAdvance();
    @(negedge clk);
  endtask

  task automatic randInputs(bit asyncOn, bit pdOn);
    orSum = 1'($urandom); ptXor = 1'($urandom); ptData = 1'($urandom);
    ptAux = 1'($urandom); ptClk = 1'($urandom); ptCe = 1'($urandom);
    pinIn = 1'($urandom); gclk = 3'($urandom); oePin = 2'($urandom);
    gclear = asyncOn && ($urandom % 8 == 0);
    ptRst = asyncOn && ($urandom % 8 == 0);
    ptSet = asyncOn && ($urandom % 6 == 0);
    pdPin = pdOn ? ((($urandom % 4) == 0) ? 2'($urandom) : 2'b00) : 2'b00;
  endtask

  task automatic runPhase(string tag, int n, bit asyncOn, bit pdOn);
    for (int i = 0; i < n; i++) begin
      randInputs(asyncOn, pdOn);
      stepCheck(tag);
    end
  endtask

  function automatic string modeTag(logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R3";
    endcase
  endfunction

  initial begin
    int seedJunk;
    seedJunk = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R13: reset state with all inputs low and registered view selected
    cfgOutReg = 1; cfgFbReg = 1; cfgPin = 1;
    #1;
    check("R13", pinOut, pinOe, feedback, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rstN = 1;
    mq = 0; mprev = 0; mhOut = 0; mhOe = 0; mhFb = 0;

    // R1: polarity operand
    cfgMode = 0; cfgOutReg = 0; cfgFbReg = 0; cfgPin = 1;
    for (int x = 0; x < 4; x++) begin cfgXor = 2'(x); runPhase("R1", 12, 0, 0); end

    // R2: data source, seen through registered feedback
    cfgFbReg = 1;
    for (int s = 0; s < 4; s++) begin
      cfgDsel = 2'(s); cfgXor = 2'($urandom); runPhase("R2", 16, 0, 0);
    end

    // R7: each clock source, D mode
    for (int c = 0; c < 4; c++) begin cfgClk = 2'(c); runPhase("R7", 20, 0, 0); end

    // R8: clock enable on globals and on product-term clock
    cfgCeEn = 1;
    for (int c = 0; c < 4; c++) begin cfgClk = 2'(c); runPhase("R8", 24, 0, 0); end
    cfgCeEn = 0;

    // R10: independent output and feedback selection
    for (int o = 0; o < 4; o++) begin
      cfgOutReg = o[0]; cfgFbReg = o[1]; cfgMode = 3'(o); runPhase("R10", 16, 0, 0);
    end

    // R11: pin direction and enable selection
    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < 4; e++) begin
        cfgPin = 2'(p); cfgOe = 2'(e); runPhase("R11", 6, 0, 0);
      end
    end

    // directed R9: reset and preset together -> reset wins
    cfgMode = 0; cfgOutReg = 1; cfgFbReg = 1; cfgPin = 1; cfgRst = 2; cfgSetEn = 1;
    randInputs(0, 0); ptRst = 1; ptSet = 1; stepCheck("R9");
    randInputs(0, 0); ptRst = 0; ptSet = 1; stepCheck("R9");
    randInputs(0, 0); ptRst = 1; ptSet = 1; stepCheck("R9");

    // directed R4/R5: both inputs high
    cfgRst = 0; cfgSetEn = 0; cfgClk = 0; cfgDsel = 1;
    for (int m = 2; m < 4; m++) begin
      cfgMode = 3'(m);
      for (int k = 0; k < 4; k++) begin
        randInputs(0, 0); gclk[0] = 0; ptData = 1; ptAux = 1; stepCheck(modeTag(3'(m)));
        randInputs(0, 0); gclk[0] = 1; ptData = 1; ptAux = 1; stepCheck(modeTag(3'(m)));
      end
    end

    // sweep: mode x clock x reset source x preset
    for (int m = 0; m < 6; m++) begin
      for (int c = 0; c < 4; c++) begin
        for (int r = 0; r < 4; r++) begin
          for (int s = 0; s < 2; s++) begin
            cfgMode = 3'(m); cfgClk = 2'(c); cfgRst = 2'(r); cfgSetEn = s[0];
            cfgDsel = 2'($urandom); cfgXor = 2'($urandom); cfgCeEn = 1'($urandom);
            cfgOutReg = 1'($urandom); cfgFbReg = 1'($urandom);
            cfgPin = 2'($urandom); cfgOe = 2'($urandom);
            runPhase(modeTag(3'(m)), 20, 1, 0);
          end
        end
      end
    end

    // R12: power-down with clocks toggling, all modes
    cfgPdEn = 1; cfgRst = 3; cfgSetEn = 1;
    for (int m = 0; m < 5; m++) begin
      cfgMode = 3'(m); cfgClk = 2'($urandom); cfgOutReg = 1; cfgFbReg = 1; cfgPin = 2;
      runPhase("R12", 60, 1, 1);
    end
    // R12: directed freeze with clock rising inside, then wake with it high
    cfgMode = 0; cfgClk = 1; cfgRst = 0; cfgSetEn = 0; cfgDsel = 1;
    randInputs(0, 0); gclk[1] = 0; ptData = 1; stepCheck("R12");
    randInputs(0, 0); gclk[1] = 0; ptData = 1; pdPin = 2'b10; stepCheck("R12");
    randInputs(0, 0); gclk[1] = 1; ptData = 1; pdPin = 2'b01; stepCheck("R12");
    randInputs(0, 0); gclk[1] = 1; ptData = 0; stepCheck("R12");
    cfgPdEn = 0;
    randInputs(0, 0); pdPin = 2'b11; stepCheck("R12");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(Period * 150000);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule